// File: doc/BRIEF.md
# Branch, Call and Return Cycle Sequencer

This block steps an 8-bit processor with a 16-bit program counter and a 16-bit stack pointer through the clock-by-clock work of its control-transfer instructions: relative branch, absolute branch, subroutine call, return, conditional return, return-from-interrupt and the register-indirect jump through HL. A decoder outside the block supplies the instruction class and the already evaluated condition. The sequencer then issues the operand reads, the stack pushes and pops and the program counter updates, and it ends with a one-cycle completion pulse. Taken and not-taken paths take different numbers of cycles.

Every instruction is split into machine cycles of four clocks. An operation happens in the second clock of its machine cycle. A read returns data one clock after its strobe, and that data is captured in the third clock. The cycle in which `start` is accepted counts as clock 1 of the instruction. `done` is high in its last clock, and `pc_out`/`sp_out` hold the final register values in that clock. The caller provides PC, SP and HL with `start`. The memory is external to the block.

Top module: `cfseq_top`

## Requirements
- R1: Class 0 (relative branch) with `cond_in`=1 reads the offset byte at PC, and `done` comes in clock 12. The final PC is PC+1 plus the offset sign-extended to 16 bits, so negative offsets branch backwards.
- R2: Class 0 with `cond_in`=0 reads the offset byte, and `done` comes in clock 8 with the final PC equal to PC+1.
- R3: Class 1 (absolute branch) reads the low target byte at PC, then the high byte at PC+1. When taken, `done` comes in clock 16 with PC = {high, low}. When not taken, `done` comes in clock 12 with PC = PC+2.
- R4: Class 2 (call) taken: `done` comes in clock 24. The block writes the high byte of the return address (PC+2) to SP-1 and then the low byte to SP-2. The final SP is SP-2 and the final PC is the target read from PC and PC+1, low byte first.
- R5: Class 2 not taken: `done` comes in clock 12, with PC = PC+2, SP unchanged and no memory write.
- R6: Class 3 (return) ignores `cond_in`. It reads the new PC low byte at SP and the high byte at SP+1, and `done` comes in clock 16 with SP = SP+2.
- R7: Class 4 (conditional return) taken pops as in R6, with `done` in clock 20. Not taken, `done` comes in clock 8 with PC and SP unchanged.
- R8: Class 5 (return from interrupt) behaves as R6. It also raises `ime_set` for exactly the `done` clock, and `ime_set` stays low for every other class.
- R9: Class 6 copies `hl_in` into PC, and `done` comes in clock 4. Class 7 does nothing and finishes in clock 4.
- R10: `done` lasts one clock. `mem_rd` and `mem_wr` are never high together. A `start` while `busy` is high is ignored and produces no extra `done` and no change of result.
- R11: After reset, `busy`, `done`, `mem_rd`, `mem_wr` and `ime_set` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction; accepted only while not busy |
| op_class | input | 3 | Instruction class 0..7 as listed in the requirements |
| cond_in | input | 1 | Condition result for the conditional classes |
| pc_in | input | 16 | Program counter at start (address after the opcode) |
| sp_in | input | 16 | Stack pointer at start |
| hl_in | input | 16 | HL register pair at start |
| mem_rdata | input | 8 | Read data, valid the clock after `mem_rd` |
| mem_addr | output | 16 | Memory address for the current strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last clock of the instruction |
| pc_out | output | 16 | Working program counter, final at `done` |
| sp_out | output | 16 | Working stack pointer, final at `done` |
| ime_set | output | 1 | Interrupt master enable set request |

## Verification
Each class runs with the condition both true and false. This separates the taken and not-taken cycle counts and shows that the unconditional classes ignore the condition. The relative branch uses a positive and a negative offset to expose a missing sign extension. A call is followed by a return from the same stack, so the byte order of the push and of the pop are both checked against memory contents. A second `start` pulse in the middle of a long branch checks that the block ignores starts while busy.

// File: rtl/cfseq_pkg.sv
// Package: instruction classes, micro-operations and the per-class
// schedule of micro-operations by machine-cycle index.
// Assumes machine cycle 0 is the opcode fetch slot (idle unless noted).
package cfseq_pkg;

    typedef enum logic [2:0] {
        CL_JR   = 3'd0,
        CL_JP   = 3'd1,
        CL_CALL = 3'd2,
        CL_RET  = 3'd3,
        CL_RETC = 3'd4,
        CL_RETI = 3'd5,
        CL_JPHL = 3'd6,
        CL_NONE = 3'd7
    } cls_e;

    typedef enum logic [3:0] {
        U_NOP,
        U_RD_LO_PC,
        U_RD_HI_PC,
        U_RD_LO_SP,
        U_RD_HI_SP,
        U_SP_DEC,
        U_WR_HI,
        U_WR_LO_JMP,
        U_ADD_REL,
        U_LOAD_TGT,
        U_LOAD_HL
    } uop_e;

    // Number of machine cycles for a class and its taken flag.
    function automatic logic [2:0] mlen(cls_e c, logic taken);
        logic [2:0] n;
        case (c)
            CL_JR:   n = taken ? 3'd3 : 3'd2;
            CL_JP:   n = taken ? 3'd4 : 3'd3;
            CL_CALL: n = taken ? 3'd6 : 3'd3;
            CL_RET:  n = 3'd4;
            CL_RETI: n = 3'd4;
            CL_RETC: n = taken ? 3'd5 : 3'd2;
            default: n = 3'd1;
        endcase
        return n;
    endfunction

    // Micro-operation executed in machine cycle m of class c.
    function automatic uop_e uop_at(cls_e c, logic [2:0] m);
        uop_e u;
        u = U_NOP;
        case (c)
            CL_JR: begin
                if (m == 3'd1) u = U_RD_LO_PC;
                if (m == 3'd2) u = U_ADD_REL;
            end
            CL_JP: begin
                if (m == 3'd1) u = U_RD_LO_PC;
                if (m == 3'd2) u = U_RD_HI_PC;
                if (m == 3'd3) u = U_LOAD_TGT;
            end
            CL_CALL: begin
                if (m == 3'd1) u = U_RD_LO_PC;
                if (m == 3'd2) u = U_RD_HI_PC;
                if (m == 3'd3) u = U_SP_DEC;
                if (m == 3'd4) u = U_WR_HI;
                if (m == 3'd5) u = U_WR_LO_JMP;
            end
            CL_RET, CL_RETI: begin
                if (m == 3'd1) u = U_RD_LO_SP;
                if (m == 3'd2) u = U_RD_HI_SP;
                if (m == 3'd3) u = U_LOAD_TGT;
            end
            CL_RETC: begin
                if (m == 3'd2) u = U_RD_LO_SP;
                if (m == 3'd3) u = U_RD_HI_SP;
                if (m == 3'd4) u = U_LOAD_TGT;
            end
            CL_JPHL: begin
                if (m == 3'd0) u = U_LOAD_HL;
            end
            default: u = U_NOP;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/cfseq_slot_ctr.sv
// Slot counter: counts clocks of one instruction, splits them into
// machine cycles and phases, and flags the final clock.
// Assumes TPM is a power of two and at least 4; tick 0 is the accept clock.
module cfseq_slot_ctr #(
    parameter int TPM  = 4,
    parameter int MMAX = 6,
    localparam int PW  = $clog2(TPM),
    localparam int TW  = $clog2(TPM * MMAX),
    localparam int MLW = $clog2(MMAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [MLW-1:0] mlen,
    output logic           active,
    output logic [TW-1:0]  tick,
    output logic           done,
    output logic           act,
    output logic           cap,
    output logic [TW-PW-1:0] mcyc
);

    logic [TW:0]   last;
    logic [PW-1:0] phase;

    // Decode the final tick and the action/capture phases.
    always_comb begin
        last  = ({{(TW + 1 - MLW){1'b0}}, mlen} << PW) - 1'b1;
        phase = tick[PW-1:0];
        mcyc  = tick[TW-1:PW];
        done  = active && ({1'b0, tick} == last);
        act   = active && (phase == PW'(1));
        cap   = active && (phase == PW'(2));
    end

    // Advance the clock index while an instruction runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            tick   <= '0;
        end else if (go) begin
            active <= 1'b1;
            tick   <= TW'(1);
        end else if (done) begin
            active <= 1'b0;
            tick   <= '0;
        end else if (active) begin
            tick <= tick + 1'b1;
        end
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done) |=> (active && tick == $past(tick) + 1'b1));

endmodule

// File: rtl/cfseq_regs.sv
// Address/data path: working PC, SP, HL and the two temp bytes; turns
// micro-operations into memory strobes and register updates.
// Assumes AW == 2*DW and that read data arrives one clock after mem_rd.
module cfseq_regs
    import cfseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] hl_in,
    input  logic          act,
    input  logic          cap,
    input  uop_e          uop,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata
);

    logic [AW-1:0] hl;
    logic [DW-1:0] tmp_lo, tmp_hi;
    logic          rd_pend, rd_to_hi;

    // Memory strobes and address for the active micro-operation.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (act) begin
            case (uop)
                U_RD_LO_PC, U_RD_HI_PC: begin
                    mem_rd   = 1'b1;
                    mem_addr = pc;
                end
                U_RD_LO_SP, U_RD_HI_SP: begin
                    mem_rd   = 1'b1;
                    mem_addr = sp;
                end
                U_WR_HI: begin
                    mem_wr    = 1'b1;
                    mem_addr  = sp;
                    mem_wdata = pc[AW-1:DW];
                end
                U_WR_LO_JMP: begin
                    mem_wr    = 1'b1;
                    mem_addr  = sp;
                    mem_wdata = pc[DW-1:0];
                end
                default: ;
            endcase
        end
    end

    // Register updates: load at accept, act on the micro-op, capture reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            sp       <= '0;
            hl       <= '0;
            tmp_lo   <= '0;
            tmp_hi   <= '0;
            rd_pend  <= 1'b0;
            rd_to_hi <= 1'b0;
        end else if (load) begin
            pc      <= pc_in;
            sp      <= sp_in;
            hl      <= hl_in;
            tmp_lo  <= '0;
            tmp_hi  <= '0;
            rd_pend <= 1'b0;
        end else begin
            if (act) begin
                rd_pend  <= uop inside {U_RD_LO_PC, U_RD_HI_PC, U_RD_LO_SP, U_RD_HI_SP};
                rd_to_hi <= uop inside {U_RD_HI_PC, U_RD_HI_SP};
                case (uop)
                    U_RD_LO_PC, U_RD_HI_PC: pc <= pc + 1'b1;
                    U_RD_LO_SP, U_RD_HI_SP: sp <= sp + 1'b1;
                    U_SP_DEC, U_WR_HI:      sp <= sp - 1'b1;
                    U_WR_LO_JMP, U_LOAD_TGT: pc <= {tmp_hi, tmp_lo};
                    U_ADD_REL: pc <= pc + {{(AW - DW){tmp_lo[DW-1]}}, tmp_lo};
                    U_LOAD_HL: pc <= hl;
                    default: ;
                endcase
            end
            if (cap && rd_pend) begin
                rd_pend <= 1'b0;
                if (rd_to_hi) tmp_hi <= mem_rdata;
                else          tmp_lo <= mem_rdata;
            end
        end
    end

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r10_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));

endmodule

// File: rtl/cfseq_top.sv
// Top: latches class and condition at accept, resolves taken/not-taken,
// drives the slot counter and the datapath from the package schedule.
// Assumes decode and condition evaluation happen outside this block.
module cfseq_top
    import cfseq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int TPM  = 4,
    parameter int MMAX = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_class,
    input  logic          cond_in,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] hl_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] sp_out,
    output logic          ime_set
);

    localparam int PW  = $clog2(TPM);
    localparam int TW  = $clog2(TPM * MMAX);
    localparam int MLW = $clog2(MMAX + 1);

    cls_e            cls_q;
    logic            cond_q;
    logic            go, taken, act, cap, active;
    logic [TW-1:0]   tick;
    logic [TW-PW-1:0] mcyc;
    logic [MLW-1:0]  len;
    uop_e            uop;

    // Accept a new instruction only when idle.
    assign go = start && !active;

    // Latch class and condition at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q  <= CL_NONE;
            cond_q <= 1'b0;
        end else if (go) begin
            cls_q  <= cls_e'(op_class);
            cond_q <= cond_in;
        end
    end

    // Resolve taken flag, length and current micro-operation.
    always_comb begin
        taken = (cls_q inside {CL_JR, CL_JP, CL_CALL, CL_RETC}) ? cond_q : 1'b1;
        len   = MLW'(mlen(cls_q, taken));
        uop   = uop_at(cls_q, 3'(mcyc));
    end

    cfseq_slot_ctr #(.TPM(TPM), .MMAX(MMAX)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .mlen   (len),
        .active (active),
        .tick   (tick),
        .done   (done),
        .act    (act),
        .cap    (cap),
        .mcyc   (mcyc)
    );

    cfseq_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (go),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .hl_in     (hl_in),
        .act       (act),
        .cap       (cap),
        .uop       (uop),
        .mem_rdata (mem_rdata),
        .pc        (pc_out),
        .sp        (sp_out),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata)
    );

    assign busy    = active;
    assign ime_set = done && (cls_q == CL_RETI);

    a_r8_ime_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ime_set |-> done);

    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start) |=> $stable(cls_q));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && !mem_rd && !mem_wr));

endmodule

// File: tb/sim_cfseq_top.sv
// Scoreboard bench: a driver task queues the expected outcome of each
// instruction and a monitor compares it at the done pulse.
module sim_cfseq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic        cond_in = 1'b0;
    logic [15:0] pc_in = '0, sp_in = '0, hl_in = '0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic        mem_rd, mem_wr, busy, done, ime_set;
    logic [7:0]  mem_wdata;

    logic [7:0] mem [0:255];

    int nchk = 0, nfail = 0, cnt = 0, odd_evt = 0;
    logic prev_done = 1'b0;

    typedef struct {
        int          cyc;
        logic [15:0] pc;
        logic [15:0] sp;
        logic        ime;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    cfseq_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
        .cond_in(cond_in), .pc_in(pc_in), .sp_in(sp_in), .hl_in(hl_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .pc_out(pc_out), .sp_out(sp_out), .ime_set(ime_set)
    );

    // Memory model: registered read, write on strobe.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] actv, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actv, expv);
        end
    endtask

    // Monitor: counts clocks per instruction and compares at done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start && !busy) cnt = 1;
            else if (busy) cnt++;
            if (mem_rd && mem_wr) odd_evt++;
            if (done && prev_done) odd_evt++;
            if (ime_set && !done) odd_evt++;
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cnt == e.cyc, e.tag, "cycles", cnt, e.cyc);
                    chk(pc_out == e.pc, e.tag, "pc", pc_out, e.pc);
                    chk(sp_out == e.sp, e.tag, "sp", sp_out, e.sp);
                    chk(ime_set == e.ime, e.tag, "ime_set", ime_set, e.ime);
                end
            end
            prev_done = done;
        end
    end

    task automatic run(input logic [2:0] c, input logic cd,
                       input logic [15:0] pc, input logic [15:0] sp,
                       input logic [15:0] hl, input int ecyc,
                       input logic [15:0] epc, input logic [15:0] esp,
                       input logic eime, input string tag, input int poke);
        exp_t e;
        e.cyc = ecyc; e.pc = epc; e.sp = esp; e.ime = eime; e.tag = tag;
        q.push_back(e);
        @(posedge clk); #2;
        start = 1'b1; op_class = c; cond_in = cd;
        pc_in = pc; sp_in = sp; hl_in = hl;
        @(posedge clk); #2;
        start = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(posedge clk);
            #2;
            start = 1'b1; op_class = 3'd6; hl_in = 16'hDEAD;
            @(posedge clk); #2;
            start = 1'b0;
        end
        do @(negedge clk); while (busy);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(!busy && !done && !mem_rd && !mem_wr && !ime_set, "R11", "idle outputs",
            {busy, done, mem_rd, mem_wr, ime_set}, 0);
        @(posedge clk); #2; rst_n = 1'b1;

        // R1: relative branch taken, positive and negative offsets
        mem[8'h30] = 8'h05;
        run(3'd0, 1'b1, 16'h1230, 16'hC000, 16'h0, 12, 16'h1236, 16'hC000, 1'b0, "R1", 0);
        mem[8'h30] = 8'hF0;
        run(3'd0, 1'b1, 16'h1230, 16'hC000, 16'h0, 12, 16'h1221, 16'hC000, 1'b0, "R1", 0);
        // R2: relative branch not taken
        run(3'd0, 1'b0, 16'h1230, 16'hC000, 16'h0, 8, 16'h1231, 16'hC000, 1'b0, "R2", 0);

        // R3: absolute branch, low byte then high byte
        mem[8'h40] = 8'h34; mem[8'h41] = 8'h12;
        run(3'd1, 1'b1, 16'h2040, 16'hC000, 16'h0, 16, 16'h1234, 16'hC000, 1'b0, "R3", 0);
        run(3'd1, 1'b0, 16'h2040, 16'hC000, 16'h0, 12, 16'h2042, 16'hC000, 1'b0, "R3", 0);

        // R4: call taken pushes return address high then low
        mem[8'h50] = 8'h78; mem[8'h51] = 8'h56;
        run(3'd2, 1'b1, 16'h3050, 16'hC0A0, 16'h0, 24, 16'h5678, 16'hC09E, 1'b0, "R4", 0);
        chk(mem[8'h9F] == 8'h30, "R4", "pushed high byte", mem[8'h9F], 8'h30);
        chk(mem[8'h9E] == 8'h52, "R4", "pushed low byte", mem[8'h9E], 8'h52);

        // R5: call not taken leaves stack untouched
        mem[8'h9C] = 8'hAA; mem[8'h9D] = 8'hAA;
        run(3'd2, 1'b0, 16'h3050, 16'hC09E, 16'h0, 12, 16'h3052, 16'hC09E, 1'b0, "R5", 0);
        chk(mem[8'h9D] == 8'hAA && mem[8'h9C] == 8'hAA, "R5", "no stack write",
            {mem[8'h9D], mem[8'h9C]}, 16'hAAAA);

        // R6: return pops the pushed address, condition ignored
        run(3'd3, 1'b0, 16'h0000, 16'hC09E, 16'h0, 16, 16'h3052, 16'hC0A0, 1'b0, "R6", 0);

        // R7: conditional return taken and not taken
        mem[8'hB0] = 8'hCD; mem[8'hB1] = 8'hAB;
        run(3'd4, 1'b1, 16'h4444, 16'hC0B0, 16'h0, 20, 16'hABCD, 16'hC0B2, 1'b0, "R7", 0);
        run(3'd4, 1'b0, 16'h4444, 16'hC0B0, 16'h0, 8, 16'h4444, 16'hC0B0, 1'b0, "R7", 0);

        // R8: return from interrupt raises ime_set at done
        run(3'd5, 1'b0, 16'h4444, 16'hC0B0, 16'h0, 16, 16'hABCD, 16'hC0B2, 1'b1, "R8", 0);

        // R9: jump through HL and the idle class
        run(3'd6, 1'b0, 16'h1111, 16'hC000, 16'hBEEF, 4, 16'hBEEF, 16'hC000, 1'b0, "R9", 0);
        run(3'd7, 1'b1, 16'h1111, 16'hC000, 16'hBEEF, 4, 16'h1111, 16'hC000, 1'b0, "R9", 0);

        // R10: start while busy is ignored
        run(3'd1, 1'b1, 16'h2040, 16'hC000, 16'h0, 16, 16'h1234, 16'hC000, 1'b0, "R10", 5);
        repeat (30) @(negedge clk);
        chk(q.size() == 0, "R10", "queue drained", q.size(), 0);
        chk(odd_evt == 0, "R10", "strobe/done anomalies", odd_evt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule